// File: doc/BRIEF.md
# UART Interrupt Identification and Line Status

This block sits between a UART's receive path, its FIFOs and its transmitter, and the register read logic of the host bus. It builds the 8-bit line-status byte. Error events (overrun, parity, framing, break) are caught in sticky flags. Live levels (data ready, transmit holding empty, transmitter idle, errored character queued) pass straight through.

It also resolves every enabled interrupt source into a single request line and an identify byte. Only the highest-priority pending source is reported. The read logic pulses `lsr_rd` when software reads the status byte and `iir_rd` when it reads the identify byte. The transmit path pulses `thr_wr` on every write to the holding register.

Top module: `uart_irq_status`

## Requirements
- R1: After a synchronous reset, with the live inputs idle and transmit holding empty and transmitter idle both high, `lsr_out` is 0x60, `iir_out` is 0xC1 and `irq` is 0.
- R2: An event pulse sets its status flag on the next clock edge: overrun to bit 1, parity to bit 2, framing to bit 3, break to bit 4. The flag holds until it is cleared.
- R3: A cycle with `lsr_rd` high clears status bits 1 to 4 at the next edge. An event pulse in that same cycle still sets its flag.
- R4: Status bit 0 follows `rx_ready`, bit 5 follows `thr_empty`, bit 6 follows `tx_idle` and bit 7 follows `rx_err_queued`, all in the same cycle.
- R5: Pending enabled sources are ranked in this order: line status (any of status bits 1 to 4), then receive trigger, then character timeout, then transmit holding empty, then modem change. `iir_out[3:0]` shows the winner's code: 0x6, 0x4, 0xC, 0x2 or 0x0. It shows 0x1 when nothing is pending.
- R6: Enable bit 0 gates receive trigger and timeout. Bit 1 gates transmit holding empty, bit 2 gates line status, and bit 3 gates modem change. With all enables low, `irq` stays 0.
- R7: The transmit-holding-empty source is armed by a rising edge of enable bit 1 or by `thr_wr`. It is pending only while `thr_empty` is high. An `iir_rd` while the identify byte shows 0x2 disarms it. An `iir_rd` while another code is shown leaves it armed.
- R8: `iir_out[7:6]` always read 11 and `iir_out[5:4]` read 00. `irq` is the inverse of `iir_out[0]`.
- R9: A break received with data ready and an errored character queued, with the transmitter idle, shows status 0xF1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_framing | input | 1 | Framing error event pulse |
| ev_break | input | 1 | Break event pulse |
| rx_ready | input | 1 | Receive data available level |
| rx_err_queued | input | 1 | At least one errored character queued in receive FIFO |
| thr_empty | input | 1 | Transmit holding register empty level |
| tx_idle | input | 1 | Transmitter completely empty level |
| rx_trig_hit | input | 1 | Receive FIFO trigger level reached |
| rx_char_tmo | input | 1 | Character timeout pending |
| modem_chg | input | 1 | Modem status change pending |
| int_en | input | 4 | Interrupt enable mask |
| lsr_rd | input | 1 | Line-status read strobe |
| iir_rd | input | 1 | Identify read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| lsr_out | output | 8 | Line-status byte |
| iir_out | output | 8 | Interrupt identify byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
A sticky flag that was lost or stuck shows up one edge after the event or the status read. It appears first as a wrong status byte, and in the same cycle as a wrong identify code when line status is enabled. A wrong arming state for transmit holding empty shows only at the identify port. So the bench checks the cycle after each enable rise, each holding write and each identify read, including a read made while a higher source is shown. Priority errors show at once, because the identify byte is computed from the current state. Each priority pair is therefore applied and checked in the same cycle.

// File: rtl/uart_irq_pkg.sv
// Package: shared widths, source ordering and identify codes for the
// UART interrupt/status block. Assumes index 0 is the highest priority.
package uart_irq_pkg;
    localparam int REG_W   = 8;
    localparam int IE_W    = 4;
    localparam int NSTICKY = 4;
    localparam int NSRC    = 5;

    typedef enum logic [3:0] {
        ID_MODEM = 4'h0,
        ID_NONE  = 4'h1,
        ID_THRE  = 4'h2,
        ID_RDA   = 4'h4,
        ID_LINE  = 4'h6,
        ID_TMO   = 4'hC
    } id_code_t;

    localparam int SRC_LINE  = 0;
    localparam int SRC_RDA   = 1;
    localparam int SRC_TMO   = 2;
    localparam int SRC_THRE  = 3;
    localparam int SRC_MODEM = 4;

    function automatic id_code_t src_code(input int idx);
        case (idx)
            SRC_LINE: return ID_LINE;
            SRC_RDA:  return ID_RDA;
            SRC_TMO:  return ID_TMO;
            SRC_THRE: return ID_THRE;
            default:  return ID_MODEM;
        endcase
    endfunction
endpackage

// File: rtl/uart_lsr_flags.sv
// Sticky error flags: each event pulse sets its flag, a status read clears
// all flags; an event in the read cycle wins. Assumes events are one-cycle pulses.
module uart_lsr_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flag_q;

    // Set on event, clear on read, set has precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (rd_clr ? '0 : flag_q) | ev;
    end

    assign flags = flag_q;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> flags[0]); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (ev == '0)) |=> (flags == '0)); // R3
endmodule

// File: rtl/uart_thre_arm.sv
// Transmit-holding-empty source tracker: armed by enable rise or a holding
// register write, disarmed when the identify read reports this source.
module uart_thre_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic en_bit,
    input  logic thr_wr,
    input  logic thr_empty,
    input  logic rd_granted,
    output logic pend
);
    logic en_q;
    logic arm_q;
    logic en_rise;

    assign en_rise = en_bit & ~en_q;

    // Remember the enable bit to detect its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_bit;
    end

    // Arm on rise or write, disarm on a read that reported this source.
    always_ff @(posedge clk) begin
        if (!rst_n)                 arm_q <= 1'b0;
        else if (en_rise || thr_wr) arm_q <= 1'b1;
        else if (rd_granted)        arm_q <= 1'b0;
    end

    assign pend = arm_q & thr_empty;

    AST_THRE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_granted && !thr_wr && !en_rise) |=> !pend); // R7
    AST_THRE_RISE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && thr_empty) |=> (pend || !thr_empty)); // R7
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority resolver: grants the lowest-index request and emits
// its identify code, or the no-interrupt code when nothing is requested.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic [3:0]   code
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Chain of "higher source already requesting" per slot.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    // Merge the code of the single granted source.
    always_comb begin
        code = seen[N] ? 4'h0 : ID_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = code | src_code(i);
        end
    end
endmodule

// File: rtl/uart_irq_status.sv
// Top: assembles the line-status byte and the identify byte, and drives
// the interrupt request. Assumes strobes are single-cycle and levels are synchronous.
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_overrun,
    input  logic              ev_parity,
    input  logic              ev_framing,
    input  logic              ev_break,
    input  logic              rx_ready,
    input  logic              rx_err_queued,
    input  logic              thr_empty,
    input  logic              tx_idle,
    input  logic              rx_trig_hit,
    input  logic              rx_char_tmo,
    input  logic              modem_chg,
    input  logic [IE_W-1:0]   int_en,
    input  logic              lsr_rd,
    input  logic              iir_rd,
    input  logic              thr_wr,
    output logic [REG_W-1:0]  lsr_out,
    output logic [REG_W-1:0]  iir_out,
    output logic              irq
);
    logic [NSTICKY-1:0] flags;
    logic [NSRC-1:0]    req;
    logic [NSRC-1:0]    grant;
    logic [3:0]         code;
    logic               thre_pend;

    uart_lsr_flags #(.N(NSTICKY)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     ({ev_break, ev_framing, ev_parity, ev_overrun}),
        .rd_clr (lsr_rd),
        .flags  (flags)
    );

    uart_thre_arm u_thre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_bit     (int_en[1]),
        .thr_wr     (thr_wr),
        .thr_empty  (thr_empty),
        .rd_granted (iir_rd & grant[SRC_THRE]),
        .pend       (thre_pend)
    );

    // Gate each source by its enable bit, in priority order.
    always_comb begin
        req            = '0;
        req[SRC_LINE]  = (|flags) & int_en[2];
        req[SRC_RDA]   = rx_trig_hit & int_en[0];
        req[SRC_TMO]   = rx_char_tmo & int_en[0];
        req[SRC_THRE]  = thre_pend & int_en[1];
        req[SRC_MODEM] = modem_chg & int_en[3];
    end

    uart_irq_prio #(.N(NSRC)) u_prio (
        .req   (req),
        .grant (grant),
        .code  (code)
    );

    assign lsr_out = {rx_err_queued, tx_idle, thr_empty, flags, rx_ready};
    assign iir_out = {2'b11, 2'b00, code};
    assign irq     = ~code[0];

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en[2] && (|lsr_out[4:1])) |-> (iir_out[3:0] == 4'h6)); // R5
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |-> !irq); // R6
endmodule

// File: tb/sim_uart_irq_status.sv
`timescale 1ns/1ps
module sim_uart_irq_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_overrun = 0, ev_parity = 0, ev_framing = 0, ev_break = 0;
    logic rx_ready = 0, rx_err_queued = 0, thr_empty = 1, tx_idle = 1;
    logic rx_trig_hit = 0, rx_char_tmo = 0, modem_chg = 0;
    logic [3:0] int_en = 4'h0;
    logic lsr_rd = 0, iir_rd = 0, thr_wr = 0;
    logic [7:0] lsr_out, iir_out;
    logic irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] lsr;
        logic [7:0] iir;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    uart_irq_status u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_overrun(ev_overrun), .ev_parity(ev_parity),
        .ev_framing(ev_framing), .ev_break(ev_break),
        .rx_ready(rx_ready), .rx_err_queued(rx_err_queued),
        .thr_empty(thr_empty), .tx_idle(tx_idle),
        .rx_trig_hit(rx_trig_hit), .rx_char_tmo(rx_char_tmo),
        .modem_chg(modem_chg), .int_en(int_en),
        .lsr_rd(lsr_rd), .iir_rd(iir_rd), .thr_wr(thr_wr),
        .lsr_out(lsr_out), .iir_out(iir_out), .irq(irq)
    );

    // Driver: inputs already set at a falling edge; queue the result expected after the next rising edge.
    task automatic expect_step(input logic [7:0] l, input logic [7:0] i, input string tag);
        exp_t e;
        e.lsr = l; e.iir = i; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic quiet();
        ev_overrun = 0; ev_parity = 0; ev_framing = 0; ev_break = 0;
        lsr_rd = 0; iir_rd = 0; thr_wr = 0;
    endtask

    // Monitor: one time unit after each rising edge, compare against the queue.
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (lsr_out !== e.lsr) begin
                n_fail++;
                $display("FAIL %s lsr actual %02h expected %02h", e.tag, lsr_out, e.lsr);
            end
            n_checks++;
            if (iir_out !== e.iir) begin
                n_fail++;
                $display("FAIL %s iir actual %02h expected %02h", e.tag, iir_out, e.iir);
            end
            n_checks++;
            if (irq !== ~e.iir[0]) begin
                n_fail++;
                $display("FAIL R8 (%s) irq actual %0b expected %0b", e.tag, irq, ~e.iir[0]);
            end
        end
    end

    initial begin
        @(negedge clk);
        expect_step(8'h60, 8'hC1, "R1 reset");
        rst_n = 1; ev_overrun = 1;
        expect_step(8'h62, 8'hC1, "R2 overrun masked");
        quiet(); int_en = 4'b0100;
        expect_step(8'h62, 8'hC6, "R6 line status enable");
        lsr_rd = 1;
        expect_step(8'h60, 8'hC1, "R3 read clears");
        quiet(); ev_parity = 1; ev_framing = 1; rx_ready = 1; rx_err_queued = 1;
        expect_step(8'hED, 8'hC6, "R2 R4 parity framing");
        quiet(); lsr_rd = 1; ev_break = 1;
        expect_step(8'hF1, 8'hC6, "R3 R9 break during read");
        quiet(); lsr_rd = 1;
        expect_step(8'hE1, 8'hC1, "R3 second read");
        quiet(); rx_err_queued = 0; int_en = 4'b0101; rx_trig_hit = 1;
        expect_step(8'h61, 8'hC4, "R5 trigger");
        rx_char_tmo = 1;
        expect_step(8'h61, 8'hC4, "R5 trigger over timeout");
        rx_trig_hit = 0;
        expect_step(8'h61, 8'hCC, "R5 timeout");
        ev_overrun = 1;
        expect_step(8'h63, 8'hC6, "R5 line over timeout");
        quiet(); lsr_rd = 1;
        expect_step(8'h61, 8'hCC, "R3 back to timeout");
        quiet(); rx_char_tmo = 0; rx_ready = 0; int_en = 4'b0011;
        expect_step(8'h60, 8'hC2, "R7 enable rise arms");
        modem_chg = 1; int_en = 4'b1011;
        expect_step(8'h60, 8'hC2, "R5 thre over modem");
        iir_rd = 1;
        expect_step(8'h60, 8'hC0, "R7 read disarms, modem shown");
        quiet(); modem_chg = 0;
        expect_step(8'h60, 8'hC1, "R7 stays disarmed");
        thr_wr = 1; thr_empty = 0; tx_idle = 0;
        expect_step(8'h00, 8'hC1, "R7 write arms, not empty");
        quiet(); thr_empty = 1;
        expect_step(8'h20, 8'hC2, "R7 empties after write");
        int_en = 4'h0;
        expect_step(8'h20, 8'hC1, "R6 all masked");
        int_en = 4'b0110; tx_idle = 1; ev_overrun = 1;
        expect_step(8'h62, 8'hC6, "R5 line over thre");
        quiet(); iir_rd = 1;
        expect_step(8'h62, 8'hC6, "R7 read of other code");
        quiet(); lsr_rd = 1;
        expect_step(8'h60, 8'hC2, "R7 still armed");
        quiet(); int_en = 4'b0001; rx_char_tmo = 1; rx_trig_hit = 0;
        expect_step(8'h60, 8'hCC, "R6 bit0 gates timeout");
        rx_char_tmo = 0;
        expect_step(8'h60, 8'hC1, "R6 nothing pending");
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule